// File: doc/BRIEF.md
# In-Order Retirement Buffer with Tag Lookup

This block keeps program order for an out-of-order core. Each instruction that issues claims a slot at the tail of a circular buffer. The slot number plus one is returned as the rename tag that reservation stations wait on. A tag value of zero is never handed out, so zero can stand for "operand already present".

The functional units broadcast results on a shared bus. A broadcast whose tag matches a waiting slot stores the value, and for stores the effective address, and marks the slot finished. Only the oldest slot can leave the buffer, and only once it is finished. A leaving arithmetic or load slot becomes a register-file write. A leaving store becomes a memory-write request. The retire output also carries the tag, so the rename table can clear a mapping that still points at it.

Issue logic has several lookup ports. Through them it can read a finished value by tag before that value has been written back to the register file.

Flow control works as follows. Allocation is a valid/ready stream: a slot is taken in a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` depends only on the full flag, never on `alloc_valid`. Retirement is a valid/ready stream: once `cm_valid` rises, its payload holds steady until a cycle with `cm_ready` high. The result bus and the execute-start strobe are broadcasts with no back-pressure.

Top module: `robq_core`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `cm_valid`=0, `alloc_ready`=1, `alloc_tag`=1, and every lookup misses.
- R2: Tags are handed out in order 1, 2, …, DEPTH and then wrap back to 1. Tag 0 is never produced. A slot is only allocated when it is free.
- R3: When DEPTH slots are occupied, `full`=1 and `alloc_ready`=0. An `alloc_valid` raised while full claims no slot and leaves `alloc_tag` unchanged.
- R4: A broadcast whose tag matches an issued or executing slot stores its value. A lookup on that tag then reports a hit with that value.
- R5: A lookup misses when its tag is 0, when the slot's result has not arrived, or when the slot is free.
- R6: Only the head slot can retire, and only once its result has arrived. A finished younger slot never raises `cm_valid` ahead of it.
- R7: Retiring an arithmetic entry (kind 0) or a load entry (kind 1) presents `cm_store`=0, the destination register, the value, the kind and the slot's tag.
- R8: Retiring a store entry (kind 2) presents `cm_store`=1, the broadcast address on `cm_addr` and the store data on `cm_value`.
- R9: While `cm_valid`=1 and `cm_ready`=0, the retire payload and `cm_valid` stay unchanged and the head does not advance.
- R10: At most one slot retires per clock cycle. An empty buffer never raises `cm_valid`, even when `cm_ready` is held high.
- R11: The execute-start strobe moves an issued slot to the executing state, and that slot still accepts its result. A broadcast to a free slot is ignored.
- R12: An allocation and a retirement in the same cycle leave the occupancy unchanged. Both pointers advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue requests a slot |
| alloc_ready | output | 1 | A slot is free |
| alloc_kind | input | 2 | Entry kind: 0 arithmetic, 1 load, 2 store |
| alloc_dest | input | REG_W | Destination register |
| alloc_tag | output | TAG_W | Tag the next allocation will receive |
| start_valid | input | 1 | Execution started for a tag |
| start_tag | input | TAG_W | Tag that started execution |
| res_valid | input | 1 | Result broadcast present |
| res_tag | input | TAG_W | Producer tag of the broadcast |
| res_value | input | DATA_W | Result value or store data |
| res_addr | input | ADDR_W | Effective address for stores |
| rd_tag | input | NRD*TAG_W | Lookup tags, port r in bits [r*TAG_W +: TAG_W] |
| rd_hit | output | NRD | Lookup found a finished value |
| rd_value | output | NRD*DATA_W | Lookup values |
| cm_valid | output | 1 | Head slot is ready to retire |
| cm_ready | input | 1 | Consumer accepts the retirement |
| cm_kind | output | 2 | Kind of the retiring entry |
| cm_store | output | 1 | Retirement is a memory write |
| cm_tag | output | TAG_W | Tag of the retiring entry |
| cm_dest | output | REG_W | Destination register |
| cm_value | output | DATA_W | Value or store data |
| cm_addr | output | ADDR_W | Store address |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |

## Verification
The bench finishes results youngest first. A buffer that retired any finished slot instead of the head would raise `cm_valid` early and retire out of order. It sends a broadcast to a free tag, which a design that accepts results into unallocated slots would turn into a lookup hit. It fills the buffer across the wrap point and pushes an allocation while full. A design without the full gate would overwrite the oldest entry or hand out a wrong tag. It also holds `cm_ready` low and issues an allocation and a retirement in the same cycle. These steps catch payloads that move under back-pressure and occupancy counts that miscount simultaneous events.

// File: rtl/robq_pkg.sv
package robq_pkg;

  typedef enum logic [1:0] {
    K_ALU   = 2'd0,
    K_LOAD  = 2'd1,
    K_STORE = 2'd2
  } op_kind_e;

  // S_FREE doubles as the retired state: a slot leaves the buffer into it.
  typedef enum logic [1:0] {
    S_FREE   = 2'd0,
    S_ISSUED = 2'd1,
    S_EXEC   = 2'd2,
    S_DONE   = 2'd3
  } slot_st_e;

endpackage

// File: rtl/robq_ptrs.sv
module robq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full,
  output logic             empty
);

  logic [CNT_W-1:0] cnt;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + IDX_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_idx <= '0;
      tail_idx <= '0;
      cnt      <= '0;
    end else begin
      if (push) tail_idx <= step(tail_idx);
      if (pop)  head_idx <= step(head_idx);
      case ({push, pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full); // R3
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R10
  AST_PAIR_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (full == $past(full)) && (empty == $past(empty))); // R12

endmodule

// File: rtl/robq_slots.sv
module robq_slots
  import robq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int ADDR_W = 32,
  parameter int NRD    = 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TAG_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_we,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  op_kind_e          alloc_kind,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic              start_valid,
  input  logic [TAG_W-1:0]  start_tag,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_value,
  input  logic [ADDR_W-1:0] res_addr,
  input  logic              free_we,
  input  logic [IDX_W-1:0]  free_idx,
  input  logic [IDX_W-1:0]  head_idx,
  input  logic [TAG_W-1:0]  rd_tag   [NRD],
  output logic              rd_hit   [NRD],
  output logic [DATA_W-1:0] rd_value [NRD],
  output slot_st_e          head_st,
  output op_kind_e          head_kind,
  output logic [REG_W-1:0]  head_dest,
  output logic [DATA_W-1:0] head_value,
  output logic [ADDR_W-1:0] head_addr
);

  slot_st_e          st    [DEPTH];
  op_kind_e          kind  [DEPTH];
  logic [REG_W-1:0]  dest  [DEPTH];
  logic [DATA_W-1:0] val   [DEPTH];
  logic [ADDR_W-1:0] addr  [DEPTH];

  // State: allocation and retirement outrank bus events, which only
  // land on slots that are still waiting for their result.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) st[i] <= S_FREE;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_we && alloc_idx == IDX_W'(i))
          st[i] <= S_ISSUED;
        else if (free_we && free_idx == IDX_W'(i))
          st[i] <= S_FREE;
        else if (res_valid && res_tag == TAG_W'(i + 1) &&
                 (st[i] == S_ISSUED || st[i] == S_EXEC))
          st[i] <= S_DONE;
        else if (start_valid && start_tag == TAG_W'(i + 1) && st[i] == S_ISSUED)
          st[i] <= S_EXEC;
      end
    end
  end

  // Payload storage needs no reset: state gates every read.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_we && alloc_idx == IDX_W'(i)) begin
        kind[i] <= alloc_kind;
        dest[i] <= alloc_dest;
      end
      if (res_valid && res_tag == TAG_W'(i + 1) &&
          (st[i] == S_ISSUED || st[i] == S_EXEC)) begin
        val[i]  <= res_value;
        addr[i] <= res_addr;
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic             r_ok;
    logic [IDX_W-1:0] r_idx;
    assign r_ok        = (rd_tag[r] != '0) && (rd_tag[r] <= TAG_W'(DEPTH));
    assign r_idx       = IDX_W'(rd_tag[r] - TAG_W'(1));
    assign rd_hit[r]   = r_ok && (st[r_idx] == S_DONE);
    assign rd_value[r] = r_ok ? val[r_idx] : '0;
  end

  assign head_st    = st[head_idx];
  assign head_kind  = kind[head_idx];
  assign head_dest  = dest[head_idx];
  assign head_value = val[head_idx];
  assign head_addr  = addr[head_idx];

  AST_ALLOC_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_we |-> st[alloc_idx] == S_FREE); // R2
  AST_FREE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    free_we |-> (st[free_idx] == S_DONE && free_idx == head_idx)); // R6

endmodule

// File: rtl/robq_retire.sv
module robq_retire
  import robq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TAG_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              empty,
  input  logic [IDX_W-1:0]  head_idx,
  input  slot_st_e          head_st,
  input  op_kind_e          head_kind,
  input  logic [REG_W-1:0]  head_dest,
  input  logic [DATA_W-1:0] head_value,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic              cm_ready,
  output logic              cm_valid,
  output logic [1:0]        cm_kind,
  output logic              cm_store,
  output logic [TAG_W-1:0]  cm_tag,
  output logic [REG_W-1:0]  cm_dest,
  output logic [DATA_W-1:0] cm_value,
  output logic [ADDR_W-1:0] cm_addr,
  output logic              pop
);

  assign cm_valid = !empty && (head_st == S_DONE);
  assign cm_kind  = head_kind;
  assign cm_store = (head_kind == K_STORE);
  assign cm_tag   = TAG_W'(head_idx) + TAG_W'(1);
  assign cm_dest  = head_dest;
  assign cm_value = head_value;
  assign cm_addr  = cm_store ? head_addr : '0;
  assign pop      = cm_valid && cm_ready;

  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_ready) |=> cm_valid && $stable(cm_tag) &&
      $stable(cm_value) && $stable(cm_dest) && $stable(cm_kind)); // R9
  AST_TAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> cm_tag != '0); // R7
  AST_NEXT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> cm_tag != $past(cm_tag)); // R10

endmodule

// File: rtl/robq_core.sv
module robq_core
  import robq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int ADDR_W = 32,
  parameter int NRD    = 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TAG_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_valid,
  output logic                  alloc_ready,
  input  logic [1:0]            alloc_kind,
  input  logic [REG_W-1:0]      alloc_dest,
  output logic [TAG_W-1:0]      alloc_tag,
  input  logic                  start_valid,
  input  logic [TAG_W-1:0]      start_tag,
  input  logic                  res_valid,
  input  logic [TAG_W-1:0]      res_tag,
  input  logic [DATA_W-1:0]     res_value,
  input  logic [ADDR_W-1:0]     res_addr,
  input  logic [NRD*TAG_W-1:0]  rd_tag,
  output logic [NRD-1:0]        rd_hit,
  output logic [NRD*DATA_W-1:0] rd_value,
  output logic                  cm_valid,
  input  logic                  cm_ready,
  output logic [1:0]            cm_kind,
  output logic                  cm_store,
  output logic [TAG_W-1:0]      cm_tag,
  output logic [REG_W-1:0]      cm_dest,
  output logic [DATA_W-1:0]     cm_value,
  output logic [ADDR_W-1:0]     cm_addr,
  output logic                  full,
  output logic                  empty
);

  logic             push, pop;
  logic [IDX_W-1:0] head_idx, tail_idx;
  slot_st_e          head_st;
  op_kind_e          head_kind;
  logic [REG_W-1:0]  head_dest;
  logic [DATA_W-1:0] head_value;
  logic [ADDR_W-1:0] head_addr;
  logic [TAG_W-1:0]  rd_tag_a   [NRD];
  logic              rd_hit_a   [NRD];
  logic [DATA_W-1:0] rd_value_a [NRD];

  assign alloc_ready = !full;
  assign push        = alloc_valid && alloc_ready;
  assign alloc_tag   = TAG_W'(tail_idx) + TAG_W'(1);

  for (genvar r = 0; r < NRD; r++) begin : g_port
    assign rd_tag_a[r]                    = rd_tag[r*TAG_W +: TAG_W];
    assign rd_hit[r]                      = rd_hit_a[r];
    assign rd_value[r*DATA_W +: DATA_W]   = rd_value_a[r];
  end

  robq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (pop),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .full     (full),
    .empty    (empty)
  );

  robq_slots #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .NRD(NRD)
  ) u_slots (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_we    (push),
    .alloc_idx   (tail_idx),
    .alloc_kind  (op_kind_e'(alloc_kind)),
    .alloc_dest  (alloc_dest),
    .start_valid (start_valid),
    .start_tag   (start_tag),
    .res_valid   (res_valid),
    .res_tag     (res_tag),
    .res_value   (res_value),
    .res_addr    (res_addr),
    .free_we     (pop),
    .free_idx    (head_idx),
    .head_idx    (head_idx),
    .rd_tag      (rd_tag_a),
    .rd_hit      (rd_hit_a),
    .rd_value    (rd_value_a),
    .head_st     (head_st),
    .head_kind   (head_kind),
    .head_dest   (head_dest),
    .head_value  (head_value),
    .head_addr   (head_addr)
  );

  robq_retire #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W)
  ) u_retire (
    .clk        (clk),
    .rst_n      (rst_n),
    .empty      (empty),
    .head_idx   (head_idx),
    .head_st    (head_st),
    .head_kind  (head_kind),
    .head_dest  (head_dest),
    .head_value (head_value),
    .head_addr  (head_addr),
    .cm_ready   (cm_ready),
    .cm_valid   (cm_valid),
    .cm_kind    (cm_kind),
    .cm_store   (cm_store),
    .cm_tag     (cm_tag),
    .cm_dest    (cm_dest),
    .cm_value   (cm_value),
    .cm_addr    (cm_addr),
    .pop        (pop)
  );

  AST_ALLOC_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ready |-> (alloc_tag != '0 && alloc_tag <= TAG_W'(DEPTH))); // R2
  AST_EMPTY_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !cm_valid); // R10
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R3

endmodule

// File: tb/robq_core_tb.sv
module robq_core_tb;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 8;
  localparam int DW     = 32;
  localparam int RW     = 5;
  localparam int AW     = 32;
  localparam int NRD    = 2;
  localparam int TW     = 4;
  localparam int NV     = 6;

  // Program table: kind, destination, result value, effective address.
  localparam logic [1:0]    T_KIND [NV] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd2, 2'd1};
  localparam logic [RW-1:0] T_DEST [NV] = '{5'd3, 5'd7, 5'd0, 5'd12, 5'd0, 5'd31};
  localparam logic [DW-1:0] T_VAL  [NV] = '{32'hA0000001, 32'h0000BEEF, 32'h12345678,
                                            32'hFFFFFFFF, 32'h00000000, 32'h5A5A5A5A};
  localparam logic [AW-1:0] T_ADDR [NV] = '{32'h0, 32'h1008, 32'h2010, 32'h0, 32'h3FF8, 32'h40};

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_valid, alloc_ready;
  logic [1:0] alloc_kind;
  logic [RW-1:0] alloc_dest;
  logic [TW-1:0] alloc_tag;
  logic start_valid;
  logic [TW-1:0] start_tag;
  logic res_valid;
  logic [TW-1:0] res_tag;
  logic [DW-1:0] res_value;
  logic [AW-1:0] res_addr;
  logic [NRD*TW-1:0] rd_tag;
  logic [NRD-1:0] rd_hit;
  logic [NRD*DW-1:0] rd_value;
  logic cm_valid, cm_ready, cm_store, full, empty;
  logic [1:0] cm_kind;
  logic [TW-1:0] cm_tag;
  logic [RW-1:0] cm_dest;
  logic [DW-1:0] cm_value;
  logic [AW-1:0] cm_addr;

  int total = 0;
  int bad   = 0;

  always #(CLK_NS / 2) clk = ~clk;

  robq_core #(.DEPTH(DEPTH), .DATA_W(DW), .REG_W(RW), .ADDR_W(AW), .NRD(NRD)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest), .alloc_tag(alloc_tag),
    .start_valid(start_valid), .start_tag(start_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value), .res_addr(res_addr),
    .rd_tag(rd_tag), .rd_hit(rd_hit), .rd_value(rd_value),
    .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_kind(cm_kind), .cm_store(cm_store),
    .cm_tag(cm_tag), .cm_dest(cm_dest), .cm_value(cm_value), .cm_addr(cm_addr),
    .full(full), .empty(empty)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_alloc(input logic [1:0] k, input logic [RW-1:0] d, input int exp_tag);
    chk("R2", "alloc_ready", 64'(alloc_ready), 64'd1);
    chk("R2", "alloc_tag", 64'(alloc_tag), 64'(exp_tag));
    alloc_valid = 1'b1; alloc_kind = k; alloc_dest = d;
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic do_result(input int t, input logic [DW-1:0] v, input logic [AW-1:0] a);
    res_valid = 1'b1; res_tag = TW'(t); res_value = v; res_addr = a;
    tick();
    res_valid = 1'b0;
  endtask

  task automatic do_commit(input string req, input int t, input logic [1:0] k,
                           input logic [RW-1:0] d, input logic [DW-1:0] v,
                           input logic [AW-1:0] a);
    chk(req, "cm_valid", 64'(cm_valid), 64'd1);
    chk(req, "cm_tag", 64'(cm_tag), 64'(t));
    chk(req, "cm_kind", 64'(cm_kind), 64'(k));
    chk(req, "cm_store", 64'(cm_store), 64'(k == 2'd2));
    chk(req, "cm_value", 64'(cm_value), 64'(v));
    if (k == 2'd2) chk(req, "cm_addr", 64'(cm_addr), 64'(a));
    else           chk(req, "cm_dest", 64'(cm_dest), 64'(d));
    cm_ready = 1'b1;
    tick();
    cm_ready = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; alloc_valid = 1'b0; alloc_kind = '0; alloc_dest = '0;
    start_valid = 1'b0; start_tag = '0; res_valid = 1'b0; res_tag = '0;
    res_value = '0; res_addr = '0; rd_tag = '0; cm_ready = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1", "empty", 64'(empty), 64'd1);
    chk("R1", "full", 64'(full), 64'd0);
    chk("R1", "cm_valid", 64'(cm_valid), 64'd0);
    chk("R1", "alloc_ready", 64'(alloc_ready), 64'd1);
    chk("R1", "alloc_tag", 64'(alloc_tag), 64'd1);
    chk("R1", "rd_hit", 64'(rd_hit), 64'd0);

    // R11 broadcast to a free slot is ignored
    do_result(3, 32'hDEADBEEF, 32'h0);
    rd_tag = {TW'(0), TW'(3)};
    #1;
    chk("R11", "stray rd_hit", 64'(rd_hit[0]), 64'd0);
    chk("R11", "stray empty", 64'(empty), 64'd1);
    chk("R11", "stray cm_valid", 64'(cm_valid), 64'd0);

    // Table walk: allocate in program order (R2)
    for (int i = 0; i < NV; i++) do_alloc(T_KIND[i], T_DEST[i], i + 1);
    chk("R2", "not empty", 64'(empty), 64'd0);
    chk("R6", "no result yet", 64'(cm_valid), 64'd0);

    // R11 execute start, then result must still land
    start_valid = 1'b1; start_tag = TW'(2);
    tick();
    start_valid = 1'b0;
    rd_tag = {TW'(0), TW'(2)};
    #1;
    chk("R5", "executing miss", 64'(rd_hit[0]), 64'd0);

    // Results youngest first; head unfinished keeps cm_valid low (R6)
    for (int i = NV - 1; i >= 1; i--) begin
      do_result(i + 1, T_VAL[i], T_ADDR[i]);
      chk("R6", "head pending", 64'(cm_valid), 64'd0);
    end
    rd_tag = {TW'(1), TW'(6)};
    #1;
    chk("R4", "hit tag6", 64'(rd_hit[0]), 64'd1);
    chk("R4", "value tag6", 64'(rd_value[DW-1:0]), 64'(T_VAL[5]));
    chk("R5", "miss tag1", 64'(rd_hit[1]), 64'd0);
    rd_tag = {TW'(0), TW'(2)};
    #1;
    chk("R11", "exec slot finished", 64'(rd_hit[0]), 64'd1);
    chk("R5", "miss tag0", 64'(rd_hit[1]), 64'd0);

    do_result(1, T_VAL[0], T_ADDR[0]);
    for (int i = 0; i < NV; i++) do_commit((T_KIND[i] == 2'd2) ? "R8" : "R7",
                                           i + 1, T_KIND[i], T_DEST[i], T_VAL[i], T_ADDR[i]);
    chk("R10", "empty after drain", 64'(empty), 64'd1);
    chk("R10", "no commit empty", 64'(cm_valid), 64'd0);
    rd_tag = {TW'(0), TW'(3)};
    #1;
    chk("R5", "freed slot miss", 64'(rd_hit[0]), 64'd0);
    cm_ready = 1'b1;
    tick();
    cm_ready = 1'b0;
    chk("R10", "ready on empty", 64'(empty), 64'd1);
    chk("R10", "tag unchanged", 64'(alloc_tag), 64'd7);

    // Fill across the wrap point (R2, R3)
    for (int j = 0; j < DEPTH; j++) do_alloc(2'd0, RW'(j + 1), ((6 + j) % DEPTH) + 1);
    chk("R3", "full", 64'(full), 64'd1);
    chk("R3", "alloc_ready", 64'(alloc_ready), 64'd0);
    alloc_valid = 1'b1; alloc_dest = 5'd30;
    tick();
    alloc_valid = 1'b0;
    chk("R3", "still full", 64'(full), 64'd1);
    chk("R3", "tag held", 64'(alloc_tag), 64'd7);

    for (int t = 1; t <= DEPTH; t++) do_result(t, DW'(32'h100 + t), 32'h0);

    // R9 back-pressure
    repeat (3) begin
      tick();
      chk("R9", "cm_valid held", 64'(cm_valid), 64'd1);
      chk("R9", "cm_tag held", 64'(cm_tag), 64'd7);
      chk("R9", "cm_value held", 64'(cm_value), 64'h107);
    end
    do_commit("R7", 7, 2'd0, 5'd1, 32'h107, 32'h0);
    chk("R3", "room again", 64'(full), 64'd0);

    // R12 simultaneous allocate and retire
    chk("R12", "pre cm_tag", 64'(cm_tag), 64'd8);
    alloc_valid = 1'b1; alloc_kind = 2'd0; alloc_dest = 5'd9; cm_ready = 1'b1;
    chk("R12", "pre alloc_tag", 64'(alloc_tag), 64'd7);
    tick();
    alloc_valid = 1'b0; cm_ready = 1'b0;
    chk("R12", "not full", 64'(full), 64'd0);
    chk("R12", "not empty", 64'(empty), 64'd0);
    chk("R12", "next alloc_tag", 64'(alloc_tag), 64'd8);
    chk("R12", "next cm_tag", 64'(cm_tag), 64'd1);

    for (int t = 1; t <= 6; t++)
      do_commit("R7", t, 2'd0, RW'(t + 2), DW'(32'h100 + t), 32'h0);
    chk("R6", "new head pending", 64'(cm_valid), 64'd0);
    do_result(7, 32'h55, 32'h0);
    do_commit("R7", 7, 2'd0, 5'd9, 32'h55, 32'h0);
    chk("R10", "final empty", 64'(empty), 64'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule